// File: doc/BRIEF.md
# Halfword Multiply-Accumulate Execution Unit

This unit is the signed DSP multiply slice of a 32-bit processor pipeline. Each cycle it can accept one 32-bit instruction word and the values already read from the register file for its operands. It decodes the halfword multiply family and returns the destination data for one of these operations:

- a 16x16 signed product;
- that product plus a 32-bit accumulator;
- that product added into a 64-bit register pair;
- a word-by-halfword product that keeps bits [47:16] of the 48-bit result, with or without a 32-bit accumulate.

Results come out one cycle after the input, together with a valid strobe, a write enable and register index for each destination word, and an undefined-instruction flag. A sticky overflow flag (Q) records signed overflow of any 32-bit accumulate. Q stays set until the pipeline pulses the clear input. The unit never produces or changes the N, Z, C or V flags.

The caller presents these values on the operand ports:

- `src_n`: the value of the register named by bits [3:0].
- `src_m`: the value of the register named by bits [11:8].
- `src_a`: the value of the register named by bits [15:12].
- `src_d`: the value of the register named by bits [19:16].

The unit does not read the register file itself.

Top module: `hmac_unit`

## Requirements
- R1: Bits [27:20] select the class of operation. 0x10 is a 16x16 multiply with a 32-bit accumulate. 0x14 is a 16x16 multiply with a 64-bit accumulate. 0x16 is a 16x16 multiply only. 0x12 is the word-by-halfword class. Any other value raises `undef` one cycle later, with both write enables low.
- R2: In the 16x16 classes, bits [7:4] must be 1,y,x,0 or the word is undefined. Bit 5 (x) set selects the top halfword of `src_n`, and clear selects the bottom halfword. Bit 6 (y) does the same for `src_m`. Both halfwords are sign-extended and multiplied as signed values.
- R3: A multiply-only form writes the product to the register named by bits [19:16] (`dst_lo_idx`), with `we_lo` high and `we_hi` low. If bits [15:12] of a multiply-only form are not zero, the word is undefined.
- R4: The 32-bit accumulate forms write product + `src_a`, wrapped to 32 bits, to the register named by bits [19:16].
- R5: Signed overflow in a 32-bit accumulate sets `q_flag`. This applies to both the 16x16 and the word-by-halfword forms. `q_flag` stays set through later operations.
- R6: The 64-bit accumulate forms add the sign-extended product to {`src_d`,`src_a`}. The low word goes out on `res_lo` to the register named by bits [15:12]. The high word goes out on `res_hi` to the register named by bits [19:16]. Both write enables are high.
- R7: 64-bit accumulate forms and multiply-only forms never change `q_flag`, even when the 64-bit sum wraps.
- R8: In the word-by-halfword class, bit 6 picks the top halfword of `src_m` and its clear state picks the bottom halfword, sign-extended in either case. The result is bits [47:16] of the signed product of `src_n` and that halfword. This truncates toward minus infinity.
- R9: In the word-by-halfword class, bits [7:4] = 1000 or 1100 are accumulate forms, and 1010 or 1110 are multiply-only forms. Any other value is undefined.
- R10: Every output is registered. `out_valid` follows `in_valid` by one cycle. A cycle without `in_valid` gives `out_valid`, `we_lo`, `we_hi` and `undef` all low on the next cycle.
- R11: `q_clear` clears `q_flag` on the next cycle. If an overflowing 32-bit accumulate arrives in the same cycle as `q_clear`, the flag is set.
- R12: While `rst` is high, all outputs and `q_flag` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| src_n | input | 32 | Value of register at bits [3:0] |
| src_m | input | 32 | Value of register at bits [11:8] |
| src_a | input | 32 | Value of register at bits [15:12] (accumulator / low pair word) |
| src_d | input | 32 | Value of register at bits [19:16] (high pair word) |
| q_clear | input | 1 | Clear the sticky overflow flag |
| out_valid | output | 1 | Result of last cycle's instruction present |
| res_lo | output | 32 | 32-bit result or low word of 64-bit sum |
| res_hi | output | 32 | High word of 64-bit sum |
| dst_lo_idx | output | 4 | Register index for `res_lo` |
| dst_hi_idx | output | 4 | Register index for `res_hi` |
| we_lo | output | 1 | Write enable for `res_lo` |
| we_hi | output | 1 | Write enable for `res_hi` |
| undef | output | 1 | Instruction word is not a valid member of the group |
| q_flag | output | 1 | Sticky signed-overflow flag |

## Verification
A wrong halfword select or a wrong decode shows up on `res_lo`, `dst_lo_idx` or the write enables in the very next cycle, because the path from input to output has only one register. A fault in the Q register is different. It can stay hidden until an overflowing accumulate sets the flag, or until a clear fails to take effect. The bench therefore checks `q_flag` one cycle after every case that sets it or clears it, and one cycle after every case that should leave it alone.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

  localparam int INSTR_W = 32;

  typedef enum logic [2:0] {
    K_MUL16  = 3'd0,  // 16x16, product only
    K_MAC16  = 3'd1,  // 16x16 + 32-bit accumulate
    K_MACL16 = 3'd2,  // 16x16 + 64-bit pair accumulate
    K_MULW   = 3'd3,  // word x halfword, product only
    K_MACW   = 3'd4,  // word x halfword + 32-bit accumulate
    K_BAD    = 3'd7
  } hmac_kind_e;

  typedef struct packed {
    hmac_kind_e kind;
    logic       n_top;
    logic       m_top;
    logic [3:0] idx_d;
    logic [3:0] idx_a;
  } hmac_dec_t;

endpackage

// File: rtl/hmac_decode.sv
module hmac_decode
  import hmac_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output hmac_dec_t          dec
);

  logic [7:0] cls;
  logic [3:0] sub;
  logic [3:0] fa;
  logic       shape16;
  logic       unused_fields;

  assign cls           = instr[27:20];
  assign sub           = instr[7:4];
  assign fa            = instr[15:12];
  assign shape16       = sub[3] & ~sub[0];
  assign unused_fields = ^{instr[31:28], instr[11:8], instr[3:0]};

  always_comb begin
    dec.n_top = instr[5];
    dec.m_top = instr[6];
    dec.idx_d = instr[19:16];
    dec.idx_a = fa;
    dec.kind  = K_BAD;
    unique case (cls)
      8'h10: if (shape16) dec.kind = K_MAC16;
      8'h14: if (shape16) dec.kind = K_MACL16;
      8'h16: if (shape16 && fa == 4'd0) dec.kind = K_MUL16;
      8'h12: begin
        unique case (sub)
          4'b1000, 4'b1100: dec.kind = K_MACW;
          4'b1010, 4'b1110: if (fa == 4'd0) dec.kind = K_MULW;
          default:          dec.kind = K_BAD;
        endcase
      end
      default: dec.kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/hmac_mult.sv
module hmac_mult #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] n,
  input  logic [DATA_W-1:0] m,
  input  logic              n_top,
  input  logic              m_top,
  input  logic              word_mode,
  output logic [DATA_W-1:0] prod
);

  localparam int HALF_W = DATA_W / 2;
  localparam int WIDE_W = DATA_W + HALF_W;

  logic signed [HALF_W-1:0] hn;
  logic signed [HALF_W-1:0] hm;
  logic signed [DATA_W-1:0] sn;
  logic signed [DATA_W-1:0] p16;
  logic signed [WIDE_W-1:0] pw;
  logic                     unused_frac;

  assign hn = n_top ? n[DATA_W-1:HALF_W] : n[HALF_W-1:0];
  assign hm = m_top ? m[DATA_W-1:HALF_W] : m[HALF_W-1:0];
  assign sn = n;

  // 16x16 signed product fits exactly in DATA_W bits
  assign p16 = hn * hm;
  // word x halfword keeps the upper DATA_W bits of the WIDE_W product
  assign pw  = sn * hm;

  assign unused_frac = ^pw[HALF_W-1:0];
  assign prod = word_mode ? pw[WIDE_W-1:HALF_W] : p16;

endmodule

// File: rtl/hmac_accum.sv
module hmac_accum #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] prod,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] acc_d,
  output logic [DATA_W-1:0] sum32,
  output logic              ovf32,
  output logic [DATA_W-1:0] pair_lo,
  output logic [DATA_W-1:0] pair_hi
);

  localparam int PAIR_W = 2 * DATA_W;

  logic [PAIR_W-1:0] pair_sum;

  assign sum32 = prod + acc_a;
  assign ovf32 = (prod[DATA_W-1] == acc_a[DATA_W-1]) &&
                 (sum32[DATA_W-1] != prod[DATA_W-1]);

  assign pair_sum = {acc_d, acc_a} + {{DATA_W{prod[DATA_W-1]}}, prod};
  assign pair_lo  = pair_sum[DATA_W-1:0];
  assign pair_hi  = pair_sum[PAIR_W-1:DATA_W];

endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
  import hmac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  src_n,
  input  logic [DATA_W-1:0]  src_m,
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_d,
  input  logic               q_clear,
  output logic               out_valid,
  output logic [DATA_W-1:0]  res_lo,
  output logic [DATA_W-1:0]  res_hi,
  output logic [IDX_W-1:0]   dst_lo_idx,
  output logic [IDX_W-1:0]   dst_hi_idx,
  output logic               we_lo,
  output logic               we_hi,
  output logic               undef,
  output logic               q_flag
);

  hmac_dec_t         dec;
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] sum32;
  logic [DATA_W-1:0] pair_lo;
  logic [DATA_W-1:0] pair_hi;
  logic              ovf32;
  logic              word_mode;
  logic              is_acc32;
  logic              is_pair;
  logic              is_bad;

  hmac_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign word_mode = (dec.kind == K_MULW) || (dec.kind == K_MACW);
  assign is_acc32  = (dec.kind == K_MAC16) || (dec.kind == K_MACW);
  assign is_pair   = (dec.kind == K_MACL16);
  assign is_bad    = (dec.kind == K_BAD);

  hmac_mult #(.DATA_W(DATA_W)) u_mul (
    .n         (src_n),
    .m         (src_m),
    .n_top     (dec.n_top),
    .m_top     (dec.m_top),
    .word_mode (word_mode),
    .prod      (prod)
  );

  hmac_accum #(.DATA_W(DATA_W)) u_acc (
    .prod    (prod),
    .acc_a   (src_a),
    .acc_d   (src_d),
    .sum32   (sum32),
    .ovf32   (ovf32),
    .pair_lo (pair_lo),
    .pair_hi (pair_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      res_lo     <= '0;
      res_hi     <= '0;
      dst_lo_idx <= '0;
      dst_hi_idx <= '0;
      we_lo      <= 1'b0;
      we_hi      <= 1'b0;
      undef      <= 1'b0;
      q_flag     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      we_lo     <= in_valid && !is_bad;
      we_hi     <= in_valid && is_pair;
      undef     <= in_valid && is_bad;
      if (in_valid) begin
        if (is_pair) begin
          res_lo     <= pair_lo;
          res_hi     <= pair_hi;
          dst_lo_idx <= IDX_W'(dec.idx_a);
          dst_hi_idx <= IDX_W'(dec.idx_d);
        end else begin
          res_lo     <= is_acc32 ? sum32 : prod;
          res_hi     <= '0;
          dst_lo_idx <= IDX_W'(dec.idx_d);
          dst_hi_idx <= '0;
        end
      end
      // a same-cycle overflow outranks the clear
      if (in_valid && is_acc32 && ovf32) q_flag <= 1'b1;
      else if (q_clear)                  q_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/hmac_unit_chk.sv
module hmac_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic        q_clear,
  input logic        out_valid,
  input logic        we_lo,
  input logic        we_hi,
  input logic        undef,
  input logic        q_flag
);

  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    undef |-> (!we_lo && !we_hi)); // R1

  AST_GOOD_WRITES_LO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !undef) |-> we_lo); // R3

  AST_HI_WITH_LO: assert property (@(posedge clk) disable iff (rst)
    we_hi |-> we_lo); // R6

  AST_Q_STICKY: assert property (@(posedge clk) disable iff (rst)
    (q_flag && !q_clear) |=> q_flag); // R5

  AST_Q_SET_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(q_flag) |-> ($past(in_valid) &&
      ($past(instr[27:20]) == 8'h10 || $past(instr[27:20]) == 8'h12))); // R7

  AST_Q_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (q_clear && !in_valid) |=> !q_flag); // R11

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !we_lo && !we_hi && !undef)); // R10

endmodule

bind hmac_unit hmac_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .instr     (instr),
  .q_clear   (q_clear),
  .out_valid (out_valid),
  .we_lo     (we_lo),
  .we_hi     (we_hi),
  .undef     (undef),
  .q_flag    (q_flag)
);

// File: tb/sim_hmac_unit.sv
module sim_hmac_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr;
  logic [31:0] src_n, src_m, src_a, src_d;
  logic        q_clear;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;
  logic [3:0]  dst_lo_idx, dst_hi_idx;
  logic        we_lo, we_hi, undef, q_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hmac_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_n(src_n), .src_m(src_m), .src_a(src_a), .src_d(src_d),
    .q_clear(q_clear), .out_valid(out_valid), .res_lo(res_lo),
    .res_hi(res_hi), .dst_lo_idx(dst_lo_idx), .dst_hi_idx(dst_hi_idx),
    .we_lo(we_lo), .we_hi(we_hi), .undef(undef), .q_flag(q_flag)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [7:0]  cls;
    logic [3:0]  fd;
    logic [3:0]  fa;
    logic [3:0]  sub;
    logic [31:0] n;
    logic [31:0] m;
    logic [31:0] a;
    logic [31:0] d;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        wl;
    logic        wh;
    logic        ud;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [0:NV-1] = '{
    // R2 R3: bottom x bottom, 3 * -2
    '{8'd2, 8'h16, 4'd3, 4'd0, 4'b1000, 32'h0005_0003, 32'h0007_FFFE, 32'h0, 32'h0, 32'hFFFF_FFFA, 32'h0, 1'b1, 1'b0, 1'b0},
    // R2: top n x bottom m, 5 * -2
    '{8'd2, 8'h16, 4'd3, 4'd0, 4'b1010, 32'h0005_0003, 32'h0007_FFFE, 32'h0, 32'h0, 32'hFFFF_FFF6, 32'h0, 1'b1, 1'b0, 1'b0},
    // R2: bottom n x top m, 3 * 7
    '{8'd2, 8'h16, 4'd9, 4'd0, 4'b1100, 32'h0005_0003, 32'h0007_FFFE, 32'h0, 32'h0, 32'h0000_0015, 32'h0, 1'b1, 1'b0, 1'b0},
    // R2: top x top, 5 * 7
    '{8'd2, 8'h16, 4'd1, 4'd0, 4'b1110, 32'h0005_0003, 32'h0007_FFFE, 32'h0, 32'h0, 32'h0000_0023, 32'h0, 1'b1, 1'b0, 1'b0},
    // R4: 16*16 + 0x100
    '{8'd4, 8'h10, 4'd4, 4'd5, 4'b1000, 32'h0000_0010, 32'h0000_0010, 32'h0000_0100, 32'h0, 32'h0000_0200, 32'h0, 1'b1, 1'b0, 1'b0},
    // R6: (-1*2) + {1,1} borrows into low word
    '{8'd6, 8'h14, 4'd6, 4'd7, 4'b1110, 32'hFFFF_0000, 32'h0002_0000, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b1, 1'b0},
    // R6: 1 + {0,FFFFFFFF} carries into high word
    '{8'd6, 8'h14, 4'd2, 4'd8, 4'b1000, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 1'b1, 1'b1, 1'b0},
    // R8: 0x10000 * 3 >> 16
    '{8'd8, 8'h12, 4'd5, 4'd0, 4'b1010, 32'h0001_0000, 32'h0000_0003, 32'h0, 32'h0, 32'h0000_0003, 32'h0, 1'b1, 1'b0, 1'b0},
    // R8: top half -2, 0x10000 * -2 >> 16
    '{8'd8, 8'h12, 4'd5, 4'd0, 4'b1110, 32'h0001_0000, 32'hFFFE_0000, 32'h0, 32'h0, 32'hFFFF_FFFE, 32'h0, 1'b1, 1'b0, 1'b0},
    // R8: -1 * 1 >> 16 floors to -1
    '{8'd8, 8'h12, 4'd5, 4'd0, 4'b1010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b0},
    // R9: word accumulate, (0x20000*5>>16)+5
    '{8'd9, 8'h12, 4'd11, 4'd12, 4'b1000, 32'h0002_0000, 32'h0000_0005, 32'h0000_0005, 32'h0, 32'h0000_000F, 32'h0, 1'b1, 1'b0, 1'b0},
    // R3: multiply-only with nonzero accumulator field
    '{8'd3, 8'h16, 4'd3, 4'd4, 4'b1000, 32'h1, 32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1},
    // R1: class outside the group
    '{8'd1, 8'h18, 4'd3, 4'd0, 4'b1000, 32'h1, 32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1},
    // R2: bit 4 set is undefined
    '{8'd2, 8'h16, 4'd3, 4'd0, 4'b1001, 32'h1, 32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1},
    // R9: word class with unlisted sub-code
    '{8'd9, 8'h12, 4'd3, 4'd4, 4'b0000, 32'h1, 32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] cls, input logic [3:0] fd,
                                     input logic [3:0] fa, input logic [3:0] sub);
    return {4'hE, cls, fd, fa, 4'd2, sub, 4'd1};
  endfunction

  // drive at a falling edge, result registered at the next rising edge,
  // sampled at the falling edge after it
  task automatic issue(input logic [31:0] iw, input logic [31:0] n, input logic [31:0] m,
                       input logic [31:0] a, input logic [31:0] d, input logic clr);
    in_valid = 1'b1; instr = iw; src_n = n; src_m = m; src_a = a; src_d = d;
    q_clear = clr;
    @(negedge clk);
    in_valid = 1'b0; q_clear = 1'b0;
  endtask

  task automatic idle(input logic clr);
    in_valid = 1'b0; q_clear = clr;
    @(negedge clk);
    q_clear = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; instr = '0; q_clear = 1'b0;
    src_n = '0; src_m = '0; src_a = '0; src_d = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R12", "res_lo", res_lo, 32'd0);
    chk("R12", "flags", {28'd0, we_lo, we_hi, undef, q_flag}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].req);
      issue(mk(VEC[i].cls, VEC[i].fd, VEC[i].fa, VEC[i].sub),
            VEC[i].n, VEC[i].m, VEC[i].a, VEC[i].d, 1'b0);
      chk(rq, $sformatf("vec%0d valid", i), {31'd0, out_valid}, 32'd1);
      chk(rq, $sformatf("vec%0d we/undef", i), {29'd0, we_lo, we_hi, undef},
          {29'd0, VEC[i].wl, VEC[i].wh, VEC[i].ud});
      if (VEC[i].wl) begin
        chk(rq, $sformatf("vec%0d res_lo", i), res_lo, VEC[i].lo);
        chk(rq, $sformatf("vec%0d lo idx", i), {28'd0, dst_lo_idx},
            {28'd0, VEC[i].wh ? VEC[i].fa : VEC[i].fd});
      end
      if (VEC[i].wh) begin
        chk(rq, $sformatf("vec%0d res_hi", i), res_hi, VEC[i].hi);
        chk(rq, $sformatf("vec%0d hi idx", i), {28'd0, dst_hi_idx}, {28'd0, VEC[i].fd});
      end
      chk("R7", $sformatf("vec%0d q untouched", i), {31'd0, q_flag}, 32'd0);
    end

    // R10: idle cycle gives quiet outputs
    idle(1'b0);
    chk("R10", "idle", {28'd0, out_valid, we_lo, we_hi, undef}, 32'd0);

    // R5: positive overflow 0x4000*0x4000 + 0x7FFFFFFF
    issue(mk(8'h10, 4'd1, 4'd2, 4'b1000), 32'h0000_4000, 32'h0000_4000,
          32'h7FFF_FFFF, 32'h0, 1'b0);
    chk("R5", "wrapped sum", res_lo, 32'h8FFF_FFFF);
    chk("R5", "q set", {31'd0, q_flag}, 32'd1);
    // R5: sticky over a non-overflowing op
    issue(mk(8'h16, 4'd1, 4'd0, 4'b1000), 32'h2, 32'h3, 32'h0, 32'h0, 1'b0);
    chk("R5", "product", res_lo, 32'h6);
    chk("R5", "q sticky", {31'd0, q_flag}, 32'd1);
    // R11: clear
    idle(1'b1);
    chk("R11", "q cleared", {31'd0, q_flag}, 32'd0);

    // R7: 64-bit wrap leaves Q clear
    issue(mk(8'h14, 4'd1, 4'd2, 4'b1000), 32'h1, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    chk("R7", "pair wrap lo", res_lo, 32'h0);
    chk("R7", "pair wrap hi", res_hi, 32'h0);
    chk("R7", "q after pair", {31'd0, q_flag}, 32'd0);

    // R5: negative overflow, -32768*32767 + 0x80000000
    issue(mk(8'h10, 4'd1, 4'd2, 4'b1000), 32'h0000_8000, 32'h0000_7FFF,
          32'h8000_0000, 32'h0, 1'b0);
    chk("R5", "neg wrapped sum", res_lo, 32'h4000_8000);
    chk("R5", "q set neg", {31'd0, q_flag}, 32'd1);
    idle(1'b1);
    chk("R11", "q cleared again", {31'd0, q_flag}, 32'd0);

    // R9 R5: word accumulate overflow, (0x7FFFFFFF*0x7FFF>>16) + 0x7FFFFFFF
    issue(mk(8'h12, 4'd1, 4'd2, 4'b1000), 32'h7FFF_FFFF, 32'h0000_7FFF,
          32'h7FFF_FFFF, 32'h0, 1'b0);
    chk("R9", "word acc wrap", res_lo, 32'hBFFF_7FFE);
    chk("R5", "q set by word acc", {31'd0, q_flag}, 32'd1);

    // R11: clear together with overflow keeps the flag set
    issue(mk(8'h10, 4'd1, 4'd2, 4'b1000), 32'h0000_4000, 32'h0000_4000,
          32'h7FFF_FFFF, 32'h0, 1'b1);
    chk("R11", "set beats clear", {31'd0, q_flag}, 32'd1);
    idle(1'b1);
    chk("R11", "final clear", {31'd0, q_flag}, 32'd0);

    // R12: reset in the middle of a run
    issue(mk(8'h10, 4'd1, 4'd2, 4'b1000), 32'h0000_4000, 32'h0000_4000,
          32'h7FFF_FFFF, 32'h0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk("R12", "reset clears", {28'd0, out_valid, we_lo, undef, q_flag}, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule